// File: doc/BRIEF.md
# Constant-Time Signed-Digit Adder

This block adds two N-digit radix-2 numbers whose digits may each be -1, 0 or +1. Because that digit set is redundant, a value can be written in more than one way. The adder uses this freedom to avoid any carry chain. The sum is formed in three cascaded digit-wise stages. A carry made in the first stage moves up one position. A carry made in the second stage moves up one more position. The last stage merges without producing a carry. No result digit therefore depends on operand digits more than two positions below it, and the delay does not grow with N.

The block is purely combinational, with no clock and no reset. Each digit travels as a two-bit pair. The upper bit is the positive flag and the lower bit is the negative flag, and the digit's value is positive minus negative. The result carries two digits more than the operands, for the following reason. The second-stage carry out of the column just above the operands can still be +1. The highest result digit holds that carry, so it is only ever 0 or +1. Dropping it would lose weight for operands near the top of their range.

Top module: `sd_adder`

## Requirements
- R1: Digit i of a vector sits in bits [2i+1:2i], with bit 2i+1 the positive flag and bit 2i the negative flag. 00 means 0, 10 means +1 and 01 means -1. The result never contains the pair 11.
- R2: Stage one maps the column sum x_i+y_i to a (carry, interim) pair: -2 gives (-1,0), -1 gives (-1,1), 0 gives (0,0), +1 gives (0,1) and +2 gives (1,0).
- R3: Stage two adds the interim digit at i to the stage-one carry from i-1, giving a value in -1..2. It maps -1 to (0,-1), 0 to (0,0), +1 to (1,-1) and +2 to (1,0).
- R4: The final stage adds the stage-two digit at i to the stage-two carry from i-1. The result is always in {-1,0,1} and needs no carry, so every result digit is a legal code.
- R5: The value of the result, the sum of d_i·2^i over N+2 digits, equals the sum of the two operand values. In particular, zero operands give an all-zero result.
- R6: Changing operand digit k alters only result digits k, k+1 and k+2. All other result digits stay the same.
- R7: No carry enters digit 0. Result digit 0 is -1 when x_0+y_0 is odd and 0 when it is even.
- R8: Result digit N+1 is never -1. It is +1 exactly when x_{N-1}+y_{N-1} equals +2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*N | First operand, N signed digits |
| op_b | input | 2*N | Second operand, N signed digits |
| sum_o | output | 2*(N+2) | Sum, N+2 signed digits |

## Verification
The hardest case to reach from the ports is a stage-two carry that must feed the highest result digit. That happens only when the stage-one carry arrives as +1 in the column above the operands. Its subtler form needs both stage-one and stage-two carries of +1 to stack on the same upper positions. Random digits rarely line up like this. So the bench drives every operand pair exhaustively on a three-digit copy of the block, and adds directed all-+1 and all-−1 operands on the eight-digit copy. Locality is checked by taking a random operand pair, changing one digit and comparing the result digits outside the three affected positions with a snapshot.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } sd_digit_t;

    typedef logic signed [2:0] sd_val_t;

    typedef struct packed {
        sd_val_t carry;
        sd_val_t sum;
    } sd_split_t;

    localparam sd_val_t SDV_M2 = -3'sd2;
    localparam sd_val_t SDV_M1 = -3'sd1;
    localparam sd_val_t SDV_0  = 3'sd0;
    localparam sd_val_t SDV_P1 = 3'sd1;
    localparam sd_val_t SDV_P2 = 3'sd2;

    function automatic sd_val_t sd_value(input sd_digit_t d);
        return sd_val_t'({2'b00, d.pos}) - sd_val_t'({2'b00, d.neg});
    endfunction

    function automatic sd_digit_t sd_encode(input sd_val_t v);
        sd_digit_t d;
        d.pos = (v == SDV_P1);
        d.neg = (v == SDV_M1);
        return d;
    endfunction

    function automatic int sd_to_int(input sd_val_t v);
        return int'(v);
    endfunction

endpackage

// File: rtl/sd_pair_split.sv
module sd_pair_split
    import sd_pkg::*;
(
    input  sd_digit_t dig_x,
    input  sd_digit_t dig_y,
    output sd_split_t split_o
);

    sd_val_t pair_sum;

    always_comb begin
        pair_sum = sd_value(dig_x) + sd_value(dig_y);
        split_o  = '{carry: SDV_0, sum: SDV_0};
        case (pair_sum)
            SDV_M2:  split_o = '{carry: SDV_M1, sum: SDV_0};
            SDV_M1:  split_o = '{carry: SDV_M1, sum: SDV_P1};
            SDV_0:   split_o = '{carry: SDV_0,  sum: SDV_0};
            SDV_P1:  split_o = '{carry: SDV_0,  sum: SDV_P1};
            SDV_P2:  split_o = '{carry: SDV_P1, sum: SDV_0};
            default: split_o = '{carry: SDV_0,  sum: SDV_0};
        endcase
    end

    always_comb begin
        if (!$isunknown({dig_x, dig_y})) begin
            AST_INPUT_LEGAL: assert (!(dig_x.pos && dig_x.neg) && !(dig_y.pos && dig_y.neg))
                else $error("operand digit uses the reserved code");  // R1
            AST_SPLIT_RANGE: assert (sd_to_int(split_o.carry) >= -1 && sd_to_int(split_o.carry) <= 1
                                     && sd_to_int(split_o.sum) >= 0 && sd_to_int(split_o.sum) <= 1)
                else $error("stage one left its range");  // R2
            AST_SPLIT_VALUE: assert (2 * sd_to_int(split_o.carry) + sd_to_int(split_o.sum)
                                     == sd_to_int(sd_value(dig_x)) + sd_to_int(sd_value(dig_y)))
                else $error("stage one changed the column value");  // R2
        end
    end

endmodule

// File: rtl/sd_mid_recode.sv
module sd_mid_recode
    import sd_pkg::*;
(
    input  sd_val_t   interim_i,
    input  sd_val_t   carry_i,
    output sd_split_t split_o
);

    sd_val_t mid_sum;

    always_comb begin
        mid_sum = interim_i + carry_i;
        split_o = '{carry: SDV_0, sum: SDV_0};
        case (mid_sum)
            SDV_M1:  split_o = '{carry: SDV_0,  sum: SDV_M1};
            SDV_0:   split_o = '{carry: SDV_0,  sum: SDV_0};
            SDV_P1:  split_o = '{carry: SDV_P1, sum: SDV_M1};
            SDV_P2:  split_o = '{carry: SDV_P1, sum: SDV_0};
            default: split_o = '{carry: SDV_0,  sum: SDV_0};
        endcase
    end

    always_comb begin
        if (!$isunknown({interim_i, carry_i})) begin
            AST_MID_IN_RANGE: assert (sd_to_int(interim_i) + sd_to_int(carry_i) >= -1
                                      && sd_to_int(interim_i) + sd_to_int(carry_i) <= 2)
                else $error("stage two input outside -1..2");  // R3
            AST_MID_OUT_RANGE: assert (sd_to_int(split_o.carry) >= 0 && sd_to_int(split_o.carry) <= 1
                                       && sd_to_int(split_o.sum) >= -1 && sd_to_int(split_o.sum) <= 0)
                else $error("stage two output outside its range");  // R3
            AST_MID_VALUE: assert (2 * sd_to_int(split_o.carry) + sd_to_int(split_o.sum)
                                   == sd_to_int(interim_i) + sd_to_int(carry_i))
                else $error("stage two changed the column value");  // R3
        end
    end

endmodule

// File: rtl/sd_final_merge.sv
module sd_final_merge
    import sd_pkg::*;
(
    input  sd_val_t   part_i,
    input  sd_val_t   carry_i,
    output sd_digit_t digit_o
);

    sd_val_t merged;

    always_comb begin
        merged  = part_i + carry_i;
        digit_o = sd_encode(merged);
    end

    always_comb begin
        if (!$isunknown({part_i, carry_i})) begin
            AST_NO_FINAL_CARRY: assert (sd_to_int(part_i) + sd_to_int(carry_i) >= -1
                                        && sd_to_int(part_i) + sd_to_int(carry_i) <= 1)
                else $error("final stage would need a carry");  // R4
            AST_DIGIT_LEGAL: assert (!(digit_o.pos && digit_o.neg))
                else $error("result digit uses the reserved code");  // R1
            AST_DIGIT_VALUE: assert (sd_to_int(sd_value(digit_o))
                                     == sd_to_int(part_i) + sd_to_int(carry_i))
                else $error("final digit does not match its inputs");  // R4
        end
    end

endmodule

// File: rtl/sd_adder.sv
module sd_adder
    import sd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0]     op_a,
    input  logic [2*N-1:0]     op_b,
    output logic [2*(N+2)-1:0] sum_o
);

    localparam int NCOL = N + 1;
    localparam int NDIG = N + 2;

    sd_digit_t             dig_a   [N];
    sd_digit_t             dig_b   [N];
    sd_split_t             st1     [N];
    sd_val_t               mid_in  [NCOL];
    sd_val_t               mid_cin [NCOL];
    sd_split_t             st2     [NCOL];
    sd_val_t               fin_cin [NCOL];
    sd_digit_t [NDIG-1:0]  res;

    for (genvar g = 0; g < N; g++) begin : g_stage1
        assign dig_a[g] = op_a[2*g +: 2];
        assign dig_b[g] = op_b[2*g +: 2];
        sd_pair_split u_split (
            .dig_x   (dig_a[g]),
            .dig_y   (dig_b[g]),
            .split_o (st1[g])
        );
    end

    for (genvar g = 0; g < NCOL; g++) begin : g_stage23
        if (g < N) begin : g_body
            assign mid_in[g] = st1[g].sum;
        end else begin : g_above
            assign mid_in[g] = SDV_0;
        end

        if (g == 0) begin : g_lsb
            assign mid_cin[g] = SDV_0;
            assign fin_cin[g] = SDV_0;
        end else begin : g_upper
            assign mid_cin[g] = st1[g-1].carry;
            assign fin_cin[g] = st2[g-1].carry;
        end

        sd_mid_recode u_mid (
            .interim_i (mid_in[g]),
            .carry_i   (mid_cin[g]),
            .split_o   (st2[g])
        );

        sd_final_merge u_fin (
            .part_i  (st2[g].sum),
            .carry_i (fin_cin[g]),
            .digit_o (res[g])
        );
    end

    assign res[NDIG-1] = sd_encode(st2[NCOL-1].carry);
    assign sum_o       = res;

    always_comb begin
        longint val_in;
        longint val_out;
        val_in  = 0;
        val_out = 0;
        for (int i = 0; i < N; i++) begin
            val_in = val_in + longint'(sd_to_int(sd_value(op_a[2*i +: 2]))) * (longint'(1) << i)
                            + longint'(sd_to_int(sd_value(op_b[2*i +: 2]))) * (longint'(1) << i);
        end
        for (int i = 0; i < NDIG; i++) begin
            val_out = val_out + longint'(sd_to_int(sd_value(sum_o[2*i +: 2]))) * (longint'(1) << i);
        end
        if (!$isunknown({op_a, op_b})) begin
            AST_SUM_VALUE: assert (val_in == val_out)
                else $error("sum value differs from operand total");  // R5
            AST_TOP_NONNEG: assert (!sum_o[2*NDIG-2])
                else $error("highest digit is negative");  // R8
        end
    end

endmodule

// File: tb/sim_sd_adder.sv
module sim_sd_adder;

    localparam int NB = 8;
    localparam int NS = 3;
    localparam int WB = 2 * (NB + 2);
    localparam int WS = 2 * (NS + 2);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [2*NB-1:0] a8 = '0;
    logic [2*NB-1:0] b8 = '0;
    logic [WB-1:0]   s8;
    logic [2*NS-1:0] a3 = '0;
    logic [2*NS-1:0] b3 = '0;
    logic [WS-1:0]   s3;

    sd_adder #(.N(NB)) u0 (.op_a(a8), .op_b(b8), .sum_o(s8));
    sd_adder #(.N(NS)) u1 (.op_a(a3), .op_b(b3), .sum_o(s3));

    typedef enum {K_VAL8, K_VAL3, K_VEC3, K_LEGAL8, K_LEGAL3, K_DIG0, K_TOP, K_SNAP, K_LOCAL} kind_e;
    typedef struct {
        kind_e         kind;
        int            expv;
        logic [WB-1:0] vec;
        string         req;
    } item_t;

    item_t         sb[$];
    int            total = 0;
    int            bad   = 0;
    logic [WB-1:0] snap  = '0;
    bit            done  = 1'b0;

    function automatic int dval(input logic [1:0] d);
        return int'(d[1]) - int'(d[0]);
    endfunction

    function automatic int vec_int(input logic [63:0] v, input int nd);
        int acc = 0;
        for (int i = 0; i < nd; i++) acc += dval(v[2*i +: 2]) * (1 << i);
        return acc;
    endfunction

    function automatic int count_bad_codes(input logic [63:0] v, input int nd);
        int c = 0;
        for (int i = 0; i < nd; i++) if (v[2*i +: 2] == 2'b11) c++;
        return c;
    endfunction

    function automatic logic [1:0] rnd_digit();
        case ($urandom_range(0, 2))
            0:       return 2'b00;
            1:       return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input kind_e k, input int expv, input logic [WB-1:0] vec, input string req);
        item_t it;
        it.kind = k;
        it.expv = expv;
        it.vec  = vec;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic drive8(input logic [2*NB-1:0] a, input logic [2*NB-1:0] b);
        @(posedge clk);
        a8 = a;
        b8 = b;
    endtask

    task automatic drive3(input logic [2*NS-1:0] a, input logic [2*NS-1:0] b);
        @(posedge clk);
        a3 = a;
        b3 = b;
    endtask

    // Monitor: compare pending expectations half a cycle after inputs change.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int    act;
            it = sb.pop_front();
            case (it.kind)
                K_VAL8: begin
                    act = vec_int(64'(s8), NB + 2);
                    check(act == it.expv, it.req, act, it.expv);
                end
                K_VAL3: begin
                    act = vec_int(64'(s3), NS + 2);
                    check(act == it.expv, it.req, act, it.expv);
                end
                K_VEC3:   check(s3 == it.vec[WS-1:0], it.req, longint'(s3), longint'(it.vec[WS-1:0]));
                K_LEGAL8: begin
                    act = count_bad_codes(64'(s8), NB + 2);
                    check(act == 0, it.req, act, 0);
                end
                K_LEGAL3: begin
                    act = count_bad_codes(64'(s3), NS + 2);
                    check(act == 0, it.req, act, 0);
                end
                K_DIG0: begin
                    act = dval(s8[1:0]);
                    check(act == it.expv, it.req, act, it.expv);
                end
                K_TOP: begin
                    act = dval(s8[WB-1 -: 2]);
                    check(act == it.expv, it.req, act, it.expv);
                end
                K_SNAP: snap = s8;
                K_LOCAL: check((s8 & it.vec) == (snap & it.vec), it.req,
                               longint'(s8 & it.vec), longint'(snap & it.vec));
                default: ;
            endcase
        end
    end

    initial begin
        // Zero operands give an all-zero sum (R5).
        drive3('0, '0);
        push(K_VEC3, 0, '0, "R5 zero operands");
        drive8('0, '0);
        push(K_VAL8, 0, '0, "R5 zero value");

        // Directed stage-one / stage-two table walks on three digits.
        drive3(6'b10_10_10, 6'b10_10_10);  // +2 columns, carries stack upward
        push(K_VEC3, 0, WB'(10'b10_00_00_01_00), "R2 column +2 row");
        push(K_VAL3, 14, '0, "R3 rows +1 into top");
        drive3(6'b01_01_01, 6'b01_01_01);  // -2 columns
        push(K_VEC3, 0, WB'(10'b00_01_01_01_00), "R2 column -2 row");
        drive3(6'b00_00_10, 6'b00_00_00);  // +1 column
        push(K_VEC3, 0, WB'(10'b00_00_00_10_01), "R3 row +1 at digit 0");
        drive3(6'b00_00_01, 6'b00_00_00);  // -1 column
        push(K_VEC3, 0, WB'(10'b00_00_00_00_01), "R3 row -1 from carry");

        // Exhaustive three-digit operands.
        for (int ia = 0; ia < 27; ia++) begin
            for (int ib = 0; ib < 27; ib++) begin
                logic [2*NS-1:0] va;
                logic [2*NS-1:0] vb;
                int ta = ia;
                int tb = ib;
                for (int d = 0; d < NS; d++) begin
                    va[2*d +: 2] = (ta % 3 == 0) ? 2'b00 : ((ta % 3 == 1) ? 2'b10 : 2'b01);
                    vb[2*d +: 2] = (tb % 3 == 0) ? 2'b00 : ((tb % 3 == 1) ? 2'b10 : 2'b01);
                    ta = ta / 3;
                    tb = tb / 3;
                end
                drive3(va, vb);
                push(K_VAL3, vec_int(64'(va), NS) + vec_int(64'(vb), NS), '0, "R5 exhaustive value");
                push(K_LEGAL3, 0, '0, "R4 exhaustive legal digits");
            end
        end

        // Directed extremes on eight digits.
        drive8({NB{2'b10}}, {NB{2'b10}});
        push(K_VAL8, 2 * ((1 << NB) - 1), '0, "R5 maximum");
        push(K_TOP, 1, '0, "R8 maximum top digit");
        drive8({NB{2'b01}}, {NB{2'b01}});
        push(K_VAL8, -2 * ((1 << NB) - 1), '0, "R5 minimum");
        push(K_TOP, 0, '0, "R8 minimum top digit");
        drive8({(NB/2){4'b10_01}}, {(NB/2){4'b01_10}});
        push(K_VAL8, 0, '0, "R5 alternating cancel");

        // Random eight-digit operands.
        for (int n = 0; n < 1500; n++) begin
            logic [2*NB-1:0] va;
            logic [2*NB-1:0] vb;
            int p0;
            int pt;
            for (int d = 0; d < NB; d++) begin
                va[2*d +: 2] = rnd_digit();
                vb[2*d +: 2] = rnd_digit();
            end
            p0 = dval(va[1:0]) + dval(vb[1:0]);
            pt = dval(va[2*NB-1 -: 2]) + dval(vb[2*NB-1 -: 2]);
            drive8(va, vb);
            push(K_VAL8, vec_int(64'(va), NB) + vec_int(64'(vb), NB), '0, "R5 random value");
            push(K_LEGAL8, 0, '0, "R1 random legal codes");
            push(K_DIG0, (p0 == 1 || p0 == -1) ? -1 : 0, '0, "R7 digit 0");
            push(K_TOP, (pt == 2) ? 1 : 0, '0, "R8 top digit");
        end

        // Locality: one operand digit changes, far digits must hold.
        for (int n = 0; n < 300; n++) begin
            logic [2*NB-1:0] va;
            logic [2*NB-1:0] vb;
            logic [1:0]      nd;
            logic [WB-1:0]   mask;
            int k;
            for (int d = 0; d < NB; d++) begin
                va[2*d +: 2] = rnd_digit();
                vb[2*d +: 2] = rnd_digit();
            end
            drive8(va, vb);
            push(K_SNAP, 0, '0, "R6 snapshot");
            k = $urandom_range(0, NB - 1);
            nd = rnd_digit();
            while (nd == va[2*k +: 2]) nd = rnd_digit();
            va[2*k +: 2] = nd;
            mask = '1;
            for (int d = k; d <= k + 2; d++) mask[2*d +: 2] = 2'b00;
            drive8(va, vb);
            push(K_LOCAL, 0, mask, "R6 carry reach");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule